// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This controller hands the external address and data buses between a processor core and a second bus master. A hold request from the other master is synchronized into the core clock domain. It is granted only once no bus transfer is in progress. On a grant, the controller raises a hold acknowledge, and one clock later it switches off the output enables for the address, data, read strobe, write strobe and memory/IO select drivers. The core keeps executing internally while it has no bus.

When the request is withdrawn, the acknowledge falls on a rising clock edge. The drivers are turned back on at the next falling edge, so the core takes the bus back half a clock after the acknowledge drops. If the core asks for a bus cycle while it does not own the bus, a stall output holds it off until the bus comes back.

Top module: `bus_hold_arb`

## Requirements
- R1: After reset, hold_ack_o is 0, all five enable outputs and core_owns_o are 1, and stall_o is 0.
- R2: With the bus idle, hold_ack_o rises on the (SYNC_STAGES+1)-th rising edge after hold_req_i goes high, and not earlier.
- R3: hold_ack_o never rises while xfer_busy_i is 1 at the deciding edge; it rises on the first rising edge that samples xfer_busy_i low with the synchronized request high.
- R4: In the cycle in which hold_ack_o is first high, the enables are still 1. All five enables go to 0 together on the next rising edge.
- R5: While hold is acknowledged, xfer_busy_i has no effect: hold_ack_o stays 1 and the enables stay 0.
- R6: hold_ack_o falls on the (SYNC_STAGES+1)-th rising edge after hold_req_i goes low.
- R7: The enables and core_owns_o return to 1 on the falling clock edge that follows the rising edge at which hold_ack_o fell.
- R8: stall_o is 1 whenever core_req_i is 1 and the core does not own the bus. Once raised, it stays 1 even after core_req_i drops, and clears when the bus is returned. It is 0 while the core owns the bus.
- R9: core_owns_o always equals each of the five enable outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; both edges used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_req_i | input | 1 | Asynchronous hold request from the other master |
| xfer_busy_i | input | 1 | A core bus transfer is in progress |
| core_req_i | input | 1 | Core wants to start a bus cycle |
| hold_ack_o | output | 1 | Hold acknowledge |
| addr_oe_o | output | 1 | Address driver enable |
| data_oe_o | output | 1 | Data driver enable |
| rd_oe_o | output | 1 | Read strobe driver enable |
| wr_oe_o | output | 1 | Write strobe driver enable |
| iom_oe_o | output | 1 | Memory/IO select driver enable |
| core_owns_o | output | 1 | Bus is granted to the core |
| stall_o | output | 1 | Core bus cycle held off |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This makes the grant and release latencies four edges instead of three, so an error in the synchronizer depth or an extra pipeline register shows up as a miscount. The bench samples both after rising edges and after falling edges. This resolves the half-cycle handback and separates it from a full-cycle return.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic {
    ST_CORE = 1'b0,
    ST_HELD = 1'b1
  } hold_st_e;

  typedef enum int unsigned {
    GRP_ADDR = 0,
    GRP_DATA = 1,
    GRP_RD   = 2,
    GRP_WR   = 3,
    GRP_IOM  = 4
  } drv_grp_e;

  localparam int unsigned NUM_GRP = 5;
endpackage

// File: rtl/bus_hold_sync.sv
module bus_hold_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_hold_fsm.sv
module bus_hold_fsm
  import bus_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic busy_i,
  output logic ack_o
);
  hold_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CORE: if (req_s_i && !busy_i) st_d = ST_HELD;
      ST_HELD: if (!req_s_i)           st_d = ST_CORE;
      default: st_d = ST_CORE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_CORE;
    else         st_q <= st_d;
  end

  assign ack_o = (st_q == ST_HELD);
endmodule

// File: rtl/bus_hold_drv.sv
module bus_hold_drv
  import bus_hold_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ack_i,
  output logic [NUM_GRP-1:0] oe_o,
  output logic               own_o
);
  // float_q: release one clock after ack rises
  // back_q:  falling-edge reg, handback half a clock after ack falls
  logic float_q;
  logic back_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) float_q <= 1'b0;
    else         float_q <= ack_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) back_q <= 1'b1;
    else         back_q <= !ack_i;
  end

  assign own_o = back_q | !float_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_oe
    assign oe_o[g] = own_o;
  end
endmodule

// File: rtl/bus_hold_stall.sv
module bus_hold_stall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic own_i,
  input  logic core_req_i,
  output logic stall_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (own_i) pend_q <= 1'b0;
    else            pend_q <= pend_q | core_req_i;
  end

  assign stall_o = !own_i && (pend_q || core_req_i);
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import bus_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic xfer_busy_i,
  input  logic core_req_i,
  output logic hold_ack_o,
  output logic addr_oe_o,
  output logic data_oe_o,
  output logic rd_oe_o,
  output logic wr_oe_o,
  output logic iom_oe_o,
  output logic core_owns_o,
  output logic stall_o
);
  logic               req_s;
  logic               ack;
  logic               own;
  logic [NUM_GRP-1:0] oe;

  bus_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (hold_req_i),
    .q_o    (req_s)
  );

  bus_hold_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_s_i (req_s),
    .busy_i  (xfer_busy_i),
    .ack_o   (ack)
  );

  bus_hold_drv u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ack),
    .oe_o   (oe),
    .own_o  (own)
  );

  bus_hold_stall u_stall (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_i      (own),
    .core_req_i (core_req_i),
    .stall_o    (stall_o)
  );

  assign hold_ack_o  = ack;
  assign core_owns_o = own;
  assign addr_oe_o   = oe[GRP_ADDR];
  assign data_oe_o   = oe[GRP_DATA];
  assign rd_oe_o     = oe[GRP_RD];
  assign wr_oe_o     = oe[GRP_WR];
  assign iom_oe_o    = oe[GRP_IOM];
endmodule

// File: rtl/bus_hold_arb_chk.sv
module bus_hold_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic xfer_busy_i,
  input logic core_req_i,
  input logic hold_ack_o,
  input logic addr_oe_o,
  input logic data_oe_o,
  input logic rd_oe_o,
  input logic wr_oe_o,
  input logic iom_oe_o,
  input logic core_owns_o,
  input logic stall_o
);
  AST_GRANT_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(!xfer_busy_i)); // R3

  AST_DRIVE_IN_ACK_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> addr_oe_o); // R4

  AST_FLOAT_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o && $past(hold_ack_o)) |-> !addr_oe_o); // R5

  AST_ENABLES_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({addr_oe_o, data_oe_o, rd_oe_o, wr_oe_o, iom_oe_o, core_owns_o}) inside {0, 6}); // R9

  AST_STALL_UNOWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !core_owns_o); // R8

  AST_STALL_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_i && !core_owns_o) |-> stall_o); // R8
endmodule

bind bus_hold_arb bus_hold_arb_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .xfer_busy_i (xfer_busy_i),
  .core_req_i  (core_req_i),
  .hold_ack_o  (hold_ack_o),
  .addr_oe_o   (addr_oe_o),
  .data_oe_o   (data_oe_o),
  .rd_oe_o     (rd_oe_o),
  .wr_oe_o     (wr_oe_o),
  .iom_oe_o    (iom_oe_o),
  .core_owns_o (core_owns_o),
  .stall_o     (stall_o)
);

// File: tb/bus_hold_arb_test.sv
`timescale 1ns/1ps
module bus_hold_arb_test;
  localparam int unsigned NS = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hold_req_i = 1'b0;
  logic xfer_busy_i = 1'b0;
  logic core_req_i = 1'b0;
  logic hold_ack_o, addr_oe_o, data_oe_o, rd_oe_o, wr_oe_o, iom_oe_o;
  logic core_owns_o, stall_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bus_hold_arb #(.SYNC_STAGES(NS)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_req_i  (hold_req_i),
    .xfer_busy_i (xfer_busy_i),
    .core_req_i  (core_req_i),
    .hold_ack_o  (hold_ack_o),
    .addr_oe_o   (addr_oe_o),
    .data_oe_o   (data_oe_o),
    .rd_oe_o     (rd_oe_o),
    .wr_oe_o     (wr_oe_o),
    .iom_oe_o    (iom_oe_o),
    .core_owns_o (core_owns_o),
    .stall_o     (stall_o)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] oe_all();
    return {addr_oe_o, data_oe_o, rd_oe_o, wr_oe_o, iom_oe_o, core_owns_o};
  endfunction

  task automatic chk_oe(string req, logic exp);
    checks++;
    if (oe_all() !== {6{exp}}) begin
      fails++;
      $display("FAIL %s oe act=%b exp=%b t=%0t", req, oe_all(), {6{exp}}, $time);
    end
  endtask

  // advance to 2 ns after the next rising edge
  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #2;
    end
  endtask

  task automatic t_reset();
    chk("R1 ack", hold_ack_o, 1'b0);
    chk_oe("R1", 1'b1);
    chk("R1 stall", stall_o, 1'b0);
  endtask

  task automatic t_grant_release();
    hold_req_i = 1'b1;
    tick(NS);
    chk("R2 ack early", hold_ack_o, 1'b0);
    tick();
    chk("R2 ack", hold_ack_o, 1'b1);
    chk_oe("R4 still driving", 1'b1);
    #4;
    chk_oe("R4 driving after negedge", 1'b1);
    tick();
    chk_oe("R4 float", 1'b0);
    hold_req_i = 1'b0;
    tick(NS);
    chk("R6 ack held", hold_ack_o, 1'b1);
    tick();
    chk("R6 ack fell", hold_ack_o, 1'b0);
    chk_oe("R7 not before negedge", 1'b0);
    #4;
    chk_oe("R7 handback", 1'b1);
    tick(2);
  endtask

  task automatic t_busy();
    xfer_busy_i = 1'b1;
    hold_req_i  = 1'b1;
    tick(NS + 3);
    chk("R3 no grant while busy", hold_ack_o, 1'b0);
    chk_oe("R3 core keeps bus", 1'b1);
    xfer_busy_i = 1'b0;
    tick();
    chk("R3 grant after busy", hold_ack_o, 1'b1);
    xfer_busy_i = 1'b1;
    tick(2);
    chk("R5 ack ignores busy", hold_ack_o, 1'b1);
    chk_oe("R5 float ignores busy", 1'b0);
    xfer_busy_i = 1'b0;
    tick();
    chk("R5 ack steady", hold_ack_o, 1'b1);
    hold_req_i = 1'b0;
    tick(NS + 1);
    #4;
    chk_oe("R7 handback after busy", 1'b1);
    tick(2);
  endtask

  task automatic t_stall();
    core_req_i = 1'b1;
    #1;
    chk("R8 no stall when owned", stall_o, 1'b0);
    core_req_i = 1'b0;
    hold_req_i = 1'b1;
    tick(NS + 2);
    chk_oe("R8 held", 1'b0);
    chk("R8 idle no stall", stall_o, 1'b0);
    core_req_i = 1'b1;
    #1;
    chk("R8 stall on req", stall_o, 1'b1);
    tick();
    core_req_i = 1'b0;
    tick();
    chk("R8 stall kept", stall_o, 1'b1);
    hold_req_i = 1'b0;
    tick(NS + 1);
    chk("R8 stall until return", stall_o, 1'b1);
    #4;
    chk("R8 stall cleared", stall_o, 1'b0);
    chk("R9 owns", core_owns_o, 1'b1);
    tick(2);
    chk("R8 stays clear", stall_o, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    tick(2);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_grant_release();
    t_busy();
    t_stall();
    t_grant_release();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule